// File: doc/BRIEF.md
# Chip Identity Authentication Enforcer

This block runs once the chip leaves reset. It reads the chip's factory-fixed 57-bit serial identity from a dedicated identity port, one bit per cycle. A keyed mixing function turns that identity into a 64-bit authorisation code. The code is compared with a reference code that the system loads from external configuration memory. The result of the comparison drives four global enforcement controls: an output-disable, a reset request, a clock enable and a protected-feature enable.

A mismatch does not have to mean the chip stops outright. A static two-bit setting picks how the chip responds to a failed check:
- full shutdown;
- basic operation with the protected feature path turned off;
- a grace window of full operation whose length is hard to predict, meant to give factory test enough time;
- that same grace window, after which a drastic-protection request is raised.

Each failed comparison adds to a saturating counter. When the count reaches a preset threshold, the lockout request is raised and then held. A retry input starts the whole check again from a failed state.

Top module: `devid_auth_ctrl`

## Requirements
- R1: After reset the block asserts `id_shift_o` for exactly 57 consecutive cycles. It samples `id_bit_i` at each of those cycles, and the first bit sampled becomes bit 56 (most significant) of the identity.
- R2: While `done_o` is low, the enforcement outputs hold the safe state: `out_disable_o`=1, `glob_reset_o`=1, `clk_en_o`=0, `feature_en_o`=0.
- R3: The code is computed in exactly 8 rounds. The start value is s = identity zero-extended to 64 bits. Each round r (0..7) computes s' = rotl13(s ^ KEY) ^ (s >> 7) ^ r, where r is zero-extended.
- R4: If the code equals `stored_code_i`, the block sets `done_o`=1 and `auth_ok_o`=1, with full operation: `out_disable_o`=0, `glob_reset_o`=0, `clk_en_o`=1, `feature_en_o`=1.
- R5: On a mismatch with `resp_mode_i`=00, the block sets `done_o`=1 and `auth_ok_o`=0, and the outputs stay in the safe state of R2.
- R6: On a mismatch with `resp_mode_i`=01, the block gives limited operation: `out_disable_o`=0, `glob_reset_o`=0, `clk_en_o`=1, `feature_en_o`=0.
- R7: On a mismatch with `resp_mode_i`=10, full operation with `grace_active_o`=1 lasts exactly L cycles, starting at the first `done_o` cycle, and then the safe state returns. L is computed as follows:
  - seed = identity[15:0], or 1 if that value is zero;
  - step the seed 8 times with v' = {v[14:0], v[15]^v[13]^v[12]^v[10]};
  - L = (v & GRACE_MASK) | GRACE_FLOOR, so L is never zero.
- R8: On a mismatch with `resp_mode_i`=11, the grace window of R7 applies. `lockout_o` is set in the first cycle after the window ends.
- R9: `fail_count_o` increments by one at each failed comparison and saturates at 15.
- R10: `lockout_o` is set at the failed comparison that brings `fail_count_o` to LOCK_THRESH or above. It then stays set until reset, including across a later successful check.
- R11: A `retry_i` pulse in a failed state restarts the identity read. `done_o` falls and the safe state returns. `retry_i` has no effect once authorised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_bit_i | input | 1 | Serial identity data, valid while `id_shift_o` is high |
| retry_i | input | 1 | Restart request, honoured only after a failed check |
| resp_mode_i | input | 2 | Static failure response: 00 off, 01 limited, 10 grace, 11 grace then lockout |
| stored_code_i | input | 64 | Reference authorisation code from configuration memory |
| id_shift_o | output | 1 | Shift strobe to the identity port |
| done_o | output | 1 | Comparison finished |
| auth_ok_o | output | 1 | Codes matched |
| out_disable_o | output | 1 | Global output-disable request |
| glob_reset_o | output | 1 | Global reset request |
| clk_en_o | output | 1 | Global clock enable |
| feature_en_o | output | 1 | Protected feature path enable |
| grace_active_o | output | 1 | Grace window running |
| fail_count_o | output | 4 | Saturating failed-attempt count |
| lockout_o | output | 1 | Sticky drastic-protection request |

## Verification
The assertions check several invariants on every clock:
- the safe state holds before completion;
- the full-run and limited output patterns match the response setting;
- the shift burst stops after the last identity bit;
- the mixer runs exactly its round count;
- the grace counter decrements by one per cycle and is never armed at zero;
- the lockout and the saturated count are sticky.

Other behaviour can only be shown by the bench scenarios. These include bit ordering and the exact code value against a reference model, the exact grace length derived from the identity (including a zero seed), the threshold crossing after repeated retries, and a retry being ignored after success.

// File: rtl/devid_auth_pkg.sv
package devid_auth_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_COMPUTE = 3'd2,
        ST_COMPARE = 3'd3,
        ST_AUTH    = 3'd4,
        ST_FAIL    = 3'd5
    } auth_state_e;

    typedef enum logic [1:0] {
        RESP_OFF        = 2'b00,
        RESP_LIMIT      = 2'b01,
        RESP_GRACE      = 2'b10,
        RESP_GRACE_LOCK = 2'b11
    } resp_mode_e;

    // Fibonacci step, polynomial x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

endpackage

// File: rtl/devid_id_reader.sv
module devid_id_reader #(
    parameter int ID_W = 57
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            en_i,
    input  logic            bit_i,
    output logic            shift_o,
    output logic            full_o,
    output logic [ID_W-1:0] id_o
);
    localparam int CNT_W = $clog2(ID_W);

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [CNT_W-1:0] cnt;
        logic             full;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.cnt  = '0;
            r_d.full = 1'b0;
        end else if (en_i && !r_q.full) begin
            r_d.id = {r_q.id[ID_W-2:0], bit_i};
            if (r_q.cnt == CNT_W'(ID_W - 1)) begin
                r_d.full = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign shift_o = en_i && !r_q.full;
    assign full_o  = r_q.full;
    assign id_o    = r_q.id;

    // R1
    shift_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o && r_q.cnt == CNT_W'(ID_W - 1)) |=> !shift_o);

    // R1
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |-> (int'(r_q.cnt) < ID_W));

endmodule

// File: rtl/devid_mixer.sv
module devid_mixer #(
    parameter int          ID_W   = 57,
    parameter int          CODE_W = 64,
    parameter logic [63:0] KEY    = 64'h9E37_79B9_7F4A_7C15,
    parameter int          ROUNDS = 8,
    parameter int          ROT    = 13,
    parameter int          SHR    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ID_W-1:0]   id_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int RND_W = $clog2(ROUNDS + 1);

    typedef struct packed {
        logic [CODE_W-1:0] st;
        logic [RND_W-1:0]  rnd;
        logic              busy;
        logic              done;
    } mix_t;

    mix_t m_d, m_q;

    function automatic logic [CODE_W-1:0] mix_round(input logic [CODE_W-1:0] s,
                                                   input logic [RND_W-1:0]  r);
        logic [CODE_W-1:0] t;
        t = s ^ CODE_W'(KEY);
        t = (t << ROT) | (t >> (CODE_W - ROT));
        return t ^ (s >> SHR) ^ CODE_W'(r);
    endfunction

    always_comb begin
        m_d      = m_q;
        m_d.done = 1'b0;
        if (start_i) begin
            m_d.st   = CODE_W'(id_i);
            m_d.rnd  = '0;
            m_d.busy = 1'b1;
        end else if (m_q.busy) begin
            m_d.st = mix_round(m_q.st, m_q.rnd);
            if (m_q.rnd == RND_W'(ROUNDS - 1)) begin
                m_d.busy = 1'b0;
                m_d.done = 1'b1;
            end else begin
                m_d.rnd = m_q.rnd + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign busy_o = m_q.busy;
    assign done_o = m_q.done;
    assign code_o = m_q.st;

    // round-length observer for the checks below
    logic [RND_W:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (start_i) begin
            busy_len_q <= '0;
        end else if (m_q.busy) begin
            busy_len_q <= busy_len_q + 1'b1;
        end
    end

    // R3
    round_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(busy_len_q) == ROUNDS));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/devid_grace_timer.sv
module devid_grace_timer import devid_auth_pkg::*; #(
    parameter logic [LFSR_W-1:0] GRACE_MASK  = 16'hFFFF,
    parameter logic [LFSR_W-1:0] GRACE_FLOOR = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              step_i,
    input  logic              arm_i,
    input  logic              abort_i,
    output logic              active_o,
    output logic              expire_o
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [LFSR_W-1:0] cnt;
    } gr_t;

    gr_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (seed_load_i) begin
            g_d.lfsr = (seed_i == '0) ? LFSR_W'(1) : seed_i;
        end else if (step_i) begin
            g_d.lfsr = lfsr_next(g_q.lfsr);
        end
        if (abort_i) begin
            g_d.cnt = '0;
        end else if (arm_i) begin
            g_d.cnt = (g_q.lfsr & GRACE_MASK) | GRACE_FLOOR;
        end else if (g_q.cnt != '0) begin
            g_d.cnt = g_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign active_o = (g_q.cnt != '0);
    assign expire_o = (g_q.cnt == LFSR_W'(1)) && !abort_i;

    // R7
    grace_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.cnt != '0 && !arm_i && !abort_i) |=> (g_q.cnt == $past(g_q.cnt) - 1'b1));

    // R7
    grace_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !abort_i) |=> active_o);

endmodule

// File: rtl/devid_auth_ctrl.sv
module devid_auth_ctrl import devid_auth_pkg::*; #(
    parameter int                ID_W        = 57,
    parameter int                CODE_W      = 64,
    parameter logic [63:0]       KEY         = 64'h9E37_79B9_7F4A_7C15,
    parameter int                ROUNDS      = 8,
    parameter int                ROT         = 13,
    parameter int                SHR         = 7,
    parameter int                FAIL_W      = 4,
    parameter logic [FAIL_W-1:0] LOCK_THRESH = 4'd8,
    parameter logic [LFSR_W-1:0] GRACE_MASK  = 16'hFFFF,
    parameter logic [LFSR_W-1:0] GRACE_FLOOR = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_bit_i,
    input  logic              retry_i,
    input  logic [1:0]        resp_mode_i,
    input  logic [CODE_W-1:0] stored_code_i,
    output logic              id_shift_o,
    output logic              done_o,
    output logic              auth_ok_o,
    output logic              out_disable_o,
    output logic              glob_reset_o,
    output logic              clk_en_o,
    output logic              feature_en_o,
    output logic              grace_active_o,
    output logic [FAIL_W-1:0] fail_count_o,
    output logic              lockout_o
);
    typedef struct packed {
        auth_state_e       st;
        logic [FAIL_W-1:0] fails;
        logic              lock;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              rd_clear, rd_full;
    logic [ID_W-1:0]   id_val;
    logic              mix_start, mix_busy, mix_done;
    logic [CODE_W-1:0] mix_code;
    logic              seed_load, g_arm, g_abort, g_active, g_expire;
    resp_mode_e        mode;

    assign mode = resp_mode_e'(resp_mode_i);

    devid_id_reader #(.ID_W(ID_W)) u_reader (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rd_clear),
        .en_i    (c_q.st == ST_LOAD),
        .bit_i   (id_bit_i),
        .shift_o (id_shift_o),
        .full_o  (rd_full),
        .id_o    (id_val)
    );

    devid_mixer #(
        .ID_W(ID_W), .CODE_W(CODE_W), .KEY(KEY),
        .ROUNDS(ROUNDS), .ROT(ROT), .SHR(SHR)
    ) u_mixer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mix_start),
        .id_i    (id_val),
        .busy_o  (mix_busy),
        .done_o  (mix_done),
        .code_o  (mix_code)
    );

    devid_grace_timer #(
        .GRACE_MASK(GRACE_MASK), .GRACE_FLOOR(GRACE_FLOOR)
    ) u_grace (
        .clk         (clk),
        .rst_n       (rst_n),
        .seed_load_i (seed_load),
        .seed_i      (id_val[LFSR_W-1:0]),
        .step_i      (mix_busy),
        .arm_i       (g_arm),
        .abort_i     (g_abort),
        .active_o    (g_active),
        .expire_o    (g_expire)
    );

    always_comb begin
        c_d       = c_q;
        rd_clear  = 1'b0;
        mix_start = 1'b0;
        seed_load = 1'b0;
        g_arm     = 1'b0;
        g_abort   = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                c_d.st   = ST_LOAD;
                rd_clear = 1'b1;
            end
            ST_LOAD: begin
                if (rd_full) begin
                    c_d.st    = ST_COMPUTE;
                    mix_start = 1'b1;
                    seed_load = 1'b1;
                end
            end
            ST_COMPUTE: begin
                if (mix_done) c_d.st = ST_COMPARE;
            end
            ST_COMPARE: begin
                if (mix_code == stored_code_i) begin
                    c_d.st = ST_AUTH;
                end else begin
                    c_d.st = ST_FAIL;
                    if (c_q.fails != '1) c_d.fails = c_q.fails + 1'b1;
                    if (c_d.fails >= LOCK_THRESH) c_d.lock = 1'b1;
                    g_arm = resp_mode_i[1];
                end
            end
            ST_AUTH: begin
                c_d.st = ST_AUTH;
            end
            ST_FAIL: begin
                if (retry_i) begin
                    c_d.st   = ST_LOAD;
                    rd_clear = 1'b1;
                    g_abort  = 1'b1;
                end else if (g_expire && mode == RESP_GRACE_LOCK) begin
                    c_d.lock = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, fails: '0, lock: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    logic in_fail, grace_on, limited, full_run;

    always_comb begin
        in_fail        = (c_q.st == ST_FAIL);
        grace_on       = in_fail && g_active;
        limited        = in_fail && (mode == RESP_LIMIT);
        full_run       = (c_q.st == ST_AUTH) || grace_on;
        done_o         = (c_q.st == ST_AUTH) || in_fail;
        auth_ok_o      = (c_q.st == ST_AUTH);
        clk_en_o       = full_run || limited;
        out_disable_o  = !(full_run || limited);
        glob_reset_o   = !(full_run || limited);
        feature_en_o   = full_run;
        grace_active_o = grace_on;
        fail_count_o   = c_q.fails;
        lockout_o      = c_q.lock;
    end

    // R2
    safe_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (out_disable_o && glob_reset_o && !clk_en_o && !feature_en_o));

    // R4
    auth_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auth_ok_o |-> (clk_en_o && feature_en_o && !out_disable_o && !glob_reset_o));

    // R5
    off_mode_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !auth_ok_o && resp_mode_i == 2'b00) |-> (out_disable_o && !clk_en_o));

    // R6
    limited_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !auth_ok_o && resp_mode_i == 2'b01) |-> (clk_en_o && !feature_en_o && !out_disable_o));

    // R8
    grace_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(grace_active_o) && done_o && resp_mode_i == 2'b11) |-> lockout_o);

    // R9
    fail_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count_o == '1) |=> (fail_count_o == '1));

    // R10
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_o |=> lockout_o);

    // R11
    auth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auth_ok_o |=> auth_ok_o);

endmodule

// File: tb/devid_auth_ctrl_tb.sv
module devid_auth_ctrl_tb;

    localparam logic [63:0] KEY_TB   = 64'h9E37_79B9_7F4A_7C15;
    localparam logic [15:0] MASK_TB  = 16'h00FF;
    localparam logic [15:0] FLOOR_TB = 16'h0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retry = 1'b0;
    logic [1:0]  resp_mode = 2'b00;
    logic [63:0] stored = '0;
    logic [56:0] dev_id = '0;
    logic        id_bit;
    logic        id_shift, done, auth_ok, out_dis, g_rst, clk_en, feat_en, grace_act, lockout;
    logic [3:0]  fail_cnt;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    devid_auth_ctrl #(
        .KEY(KEY_TB), .LOCK_THRESH(4'd3),
        .GRACE_MASK(MASK_TB), .GRACE_FLOOR(FLOOR_TB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .id_bit_i(id_bit), .retry_i(retry),
        .resp_mode_i(resp_mode), .stored_code_i(stored),
        .id_shift_o(id_shift), .done_o(done), .auth_ok_o(auth_ok),
        .out_disable_o(out_dis), .glob_reset_o(g_rst), .clk_en_o(clk_en),
        .feature_en_o(feat_en), .grace_active_o(grace_act),
        .fail_count_o(fail_cnt), .lockout_o(lockout)
    );

    // serial identity source and burst-length observer
    logic [6:0] idx = '0;
    logic [6:0] last_len = '0;
    assign id_bit = (idx < 7'd57) ? dev_id[56 - idx] : 1'b0;
    always @(posedge clk) begin
        if (id_shift) begin
            idx <= idx + 1'b1;
        end else if (idx != 0) begin
            last_len <= idx;
            idx      <= '0;
        end
    end

    function automatic logic [63:0] model_code(input logic [56:0] id);
        logic [63:0] s, t;
        s = {7'b0, id};
        for (int r = 0; r < 8; r++) begin
            t = s ^ KEY_TB;
            t = {t[50:0], t[63:51]};
            s = t ^ (s >> 7) ^ 64'(r);
        end
        return s;
    endfunction

    function automatic int model_grace(input logic [56:0] id);
        logic [15:0] l;
        l = id[15:0];
        if (l == 16'h0) l = 16'h1;
        for (int k = 0; k < 8; k++) l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
        return int'((l & MASK_TB) | FLOOR_TB);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // scoreboard: expected result of each completed check
    typedef struct packed {
        logic       auth;
        logic [3:0] cnt;
        logic       lock;
    } exp_t;
    exp_t sb_q[$];

    task automatic push_exp(input logic a, input logic [3:0] c, input logic l);
        exp_t e;
        e.auth = a; e.cnt = c; e.lock = l;
        sb_q.push_back(e);
    endtask

    always @(posedge done) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
            check(1'b0, "R4 scoreboard unexpected completion", 1, 0);
        end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(auth_ok == e.auth, "R4/R5 auth result", auth_ok, e.auth);
            check(fail_cnt == e.cnt, "R9 fail count", fail_cnt, e.cnt);
            check(lockout == e.lock, "R10 lockout at completion", lockout, e.lock);
            check(last_len == 7'd57, "R1 shift burst length", last_len, 57);
        end
    end

    task automatic start_case(input logic [1:0] mode, input logic [56:0] id, input bit good);
        rst_n     = 1'b0;
        retry     = 1'b0;
        resp_mode = mode;
        dev_id    = id;
        stored    = good ? model_code(id) : (model_code(id) ^ 64'h1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_retry();
        retry = 1'b1;
        @(negedge clk);
        retry = 1'b0;
    endtask

    task automatic check_safe(input string req);
        check(out_dis && g_rst && !clk_en && !feat_en, req,
              {out_dis, g_rst, clk_en, feat_en}, 4'b1100);
    endtask

    localparam logic [56:0] ID_A = 57'h1A5C3F09B2D7E41;
    localparam logic [56:0] ID_B = 57'h0F3E2D1C0B0A998;
    localparam logic [56:0] ID_Z = 57'h123456789AB0000;

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R2 reset state and pre-completion safe state; R4 match with full run
        push_exp(1'b1, 4'd0, 1'b0);
        start_case(2'b00, ID_A, 1'b1);
        @(negedge clk);
        check(!done && fail_cnt == 0 && !lockout, "R2 reset state",
              {done, fail_cnt, lockout}, 0);
        check_safe("R2 safe before done");
        wait_done();
        check(!out_dis && !g_rst && clk_en && feat_en, "R4 full run on match",
              {out_dis, g_rst, clk_en, feat_en}, 4'b0011);
        // R11 retry ignored once authorised
        pulse_retry();
        repeat (4) @(negedge clk);
        check(done && auth_ok && !id_shift && feat_en, "R11 retry ignored after success",
              {done, auth_ok, id_shift, feat_en}, 4'b1101);

        // R3 second identity exercises the transform with other bits; R5 off mode
        push_exp(1'b1, 4'd0, 1'b0);
        start_case(2'b00, ID_B, 1'b1);
        wait_done();
        check(auth_ok, "R3 code model match for second identity", auth_ok, 1);

        push_exp(1'b0, 4'd1, 1'b0);
        start_case(2'b00, ID_B, 1'b0);
        wait_done();
        check_safe("R5 off-mode shutdown");

        // R6 limited mode
        push_exp(1'b0, 4'd1, 1'b0);
        start_case(2'b01, ID_A, 1'b0);
        wait_done();
        check(!out_dis && !g_rst && clk_en && !feat_en, "R6 limited operation",
              {out_dis, g_rst, clk_en, feat_en}, 4'b0010);
        repeat (20) @(negedge clk);
        check(clk_en && !feat_en, "R6 limited operation persists", {clk_en, feat_en}, 2'b10);

        // R7 timed grace
        push_exp(1'b0, 4'd1, 1'b0);
        start_case(2'b10, ID_A, 1'b0);
        wait_done();
        check(grace_act && feat_en, "R7 grace active at completion", {grace_act, feat_en}, 2'b11);
        begin
            int n = 0;
            while (clk_en && n < 70000) begin
                n++;
                @(negedge clk);
            end
            check(n == model_grace(ID_A), "R7 grace length", n, model_grace(ID_A));
        end
        check_safe("R7 shutdown after grace");
        check(!lockout && !grace_act, "R7 no lockout in grace-only mode", {lockout, grace_act}, 0);

        // R8 grace then lockout, zero low seed
        push_exp(1'b0, 4'd1, 1'b0);
        start_case(2'b11, ID_Z, 1'b0);
        wait_done();
        begin
            int n = 0;
            while (clk_en && n < 70000) begin
                n++;
                @(negedge clk);
            end
            check(n == model_grace(ID_Z), "R8 grace length with zero seed", n, model_grace(ID_Z));
        end
        check(lockout, "R8 lockout after grace", lockout, 1);

        // R9 R10 R11 repeated retries in off mode
        push_exp(1'b0, 4'd1, 1'b0);
        start_case(2'b00, ID_A, 1'b0);
        wait_done();
        for (int i = 2; i <= 17; i++) begin
            push_exp(1'b0, (i > 15) ? 4'd15 : 4'(i), (i >= 3));
            pulse_retry();
            check(!done, "R11 retry restarts check", done, 0);
            check_safe("R11 safe state during retry");
            wait_done();
            @(negedge clk);
        end
        check(fail_cnt == 4'd15, "R9 saturation", fail_cnt, 15);

        // R10 lockout sticky across a later successful check
        push_exp(1'b1, 4'd15, 1'b1);
        stored = model_code(ID_A);
        pulse_retry();
        wait_done();
        @(negedge clk);
        check(auth_ok && lockout, "R10 lockout sticky after success", {auth_ok, lockout}, 2'b11);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);
        summary();
        $finish;
    end

endmodule